// File: doc/BRIEF.md
# SD Card SPI-Mode Data Block Writer

This block runs the data phase of an SD card write in SPI mode, after the command engine has had the write command accepted. A single-block job sends one block. A multi-block job sends a chosen number of blocks. Each block is framed by a start token and a CRC16. The 512 payload bytes come from a valid/ready byte stream. Every byte on the wire goes through a byte-exchange handshake with an external SPI shifter: the block offers one byte to send, and takes back the byte the card returned in the same exchange.

After each block's CRC, the block reads one data-response byte. A rejected block ends the job. An accepted block is followed by a busy wait, in which the block keeps polling until the card stops returning zero bytes. A card that releases MISO part-way through a byte returns one odd byte; the block reads one more byte and accepts it if it is 0xFF. In multi-block mode, after the last block's busy wait the block asks the command engine, through a request/acknowledge pair, to send the stop command, and then waits out busy again. The job ends with a one-cycle `done` pulse and a three-bit status code.

State machine: `S_IDLE` goes to `S_TOKEN` on start. `S_TOKEN` goes to `S_DATA`. `S_DATA` goes to `S_CRC_HI` after the last payload byte. Then `S_CRC_LO`, then `S_RESP`. `S_RESP` goes to `S_BUSY` on accept, or to `S_FINISH` on reject. `S_BUSY` loops on 0x00, goes to `S_RECHECK` on an odd byte, or leaves when ready. `S_RECHECK` leaves when ready or goes to `S_FINISH` with a protocol error. When the card is ready, the next state depends on the job:
- the next block's `S_TOKEN` if blocks remain in a multi-block job;
- `S_STOP` after the last block of a multi-block job;
- `S_FINISH` after the stop, or when the job is single-block.

`S_STOP` goes to `S_BUSY` on acknowledge, and `S_FINISH` returns to `S_IDLE`.

Top module: `sd_blk_writer`

## Requirements
- R1: Each block starts with one token byte: 0xFE when `multi` was low at start, 0xFC for every block when `multi` was high.
- R2: After the token, exactly BLK_BYTES payload bytes are sent in stream order. `pl_ready` is high only in a cycle where the current byte is exchanged. A stream byte, once offered, must be held until it is taken.
- R3: After the payload come two bytes holding the CRC16 (polynomial 0x1021, initial value 0, MSB-first bit order) over the payload, high byte first.
- R4: The next exchange (send 0xFF) reads the data response, decoded on bits [4:0]. 00101 accepts the block. 01011 ends the job with status 1, 01101 ends it with status 2, and any other value ends it with status 3. A rejected block gets no busy poll.
- R5: In the busy wait each poll sends 0xFF. A returned 0x00 means poll again; 0xFF means the card is ready.
- R6: Any other returned byte causes exactly one more poll. 0xFF on that poll means ready; anything else ends the job with status 4.
- R7: If BUSY_POLLS consecutive polls all return 0x00, the job ends with status 5 after exactly that many polls. BUSY_POLLS-1 zeros followed by 0xFF still succeed.
- R8: In multi-block mode `nblk` blocks are sent (0 counts as 1), with a busy wait after each. After the last block, `stop_req` is held until `stop_ack`; a second busy wait follows, then the job ends. `stop_req` is never high together with `byte_req`.
- R9: Out of reset, `busy`, `done`, `byte_req` and `stop_req` are low. `busy` rises the cycle after a start accepted while idle and stays high through the single `done` cycle. Status is 0 on success. A start while busy is ignored.
- R10: A byte offered on `byte_req` that is not granted stays offered, with the same value, in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a job (taken only while idle) |
| multi | input | 1 | 1 = multi-block job, 0 = single block |
| nblk | input | CNT_W | Block count for a multi-block job |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| status | output | 3 | 0 ok, 1 CRC reject, 2 write reject, 3 bad response, 4 protocol, 5 timeout |
| pl_valid | input | 1 | Payload byte offered |
| pl_data | input | 8 | Payload byte |
| pl_ready | output | 1 | Payload byte taken this cycle |
| byte_req | output | 1 | Byte exchange requested |
| byte_tx | output | 8 | Byte to send to the card |
| byte_gnt | input | 1 | Exchange completes this cycle |
| byte_rx | input | 8 | Byte returned by the card, valid with the grant |
| stop_req | output | 1 | Ask the command engine for the stop command |
| stop_ack | input | 1 | Stop command issued |

## Verification
On every cycle the assertions check three groups of properties. The first is the exchange and stop handshakes: an offered byte is held, and a stop request is held until it is acknowledged. The second is that the payload is taken only while its byte is on the wire, and that stop and byte requests never overlap. The third is the shape of `done` and `busy`: `done` is a single-cycle pulse and `busy` rises after a start. The byte-for-byte stream can be shown only by the bench's scenarios, whose reference queue checks every exchange. That stream covers the tokens, the CRC values, the data-response decoding, the odd-byte recheck, the exact timeout count and the stop sequence in multi-block jobs.

// File: rtl/sdw_pkg.sv
package sdw_pkg;

    typedef enum logic [3:0] {
        S_IDLE, S_TOKEN, S_DATA, S_CRC_HI, S_CRC_LO,
        S_RESP, S_BUSY, S_RECHECK, S_STOP, S_FINISH
    } sdw_state_t;

    typedef enum logic [2:0] {
        ST_OK       = 3'd0,
        ST_CRC_REJ  = 3'd1,
        ST_WR_REJ   = 3'd2,
        ST_BAD_RESP = 3'd3,
        ST_PROTO    = 3'd4,
        ST_TIMEOUT  = 3'd5
    } sdw_status_t;

    typedef enum logic [1:0] {
        RSP_ACCEPT, RSP_CRC, RSP_WRITE, RSP_OTHER
    } sdw_rsp_t;

    localparam logic [7:0] TOK_ONE   = 8'hFE;
    localparam logic [7:0] TOK_MULTI = 8'hFC;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;
    localparam logic [7:0] BUSY_BYTE = 8'h00;

endpackage

// File: rtl/sdw_crc16.sv
module sdw_crc16 #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    logic [15:0] crc_q;
    logic [15:0] crc_d;

    // Eight serial steps folded into one byte-wide update.
    always_comb begin
        crc_d = crc_q;
        for (int k = 7; k >= 0; k--) begin
            if (crc_d[15] ^ din[k]) crc_d = {crc_d[14:0], 1'b0} ^ POLY;
            else                    crc_d = {crc_d[14:0], 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) crc_q <= '0;
        else if (en)         crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/sdw_rsp_decode.sv
module sdw_rsp_decode
    import sdw_pkg::*;
(
    input  logic [7:0] rx,
    output sdw_rsp_t   kind
);
    always_comb begin
        unique case (rx[4:0])
            5'b00101: kind = RSP_ACCEPT;
            5'b01011: kind = RSP_CRC;
            5'b01101: kind = RSP_WRITE;
            default:  kind = RSP_OTHER;
        endcase
    end
endmodule

// File: rtl/sdw_poll_timer.sv
module sdw_poll_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (tick)       cnt_q <= cnt_q + 1'b1;
    end

    assign last = (cnt_q == W'(LIMIT - 1));
endmodule

// File: rtl/sd_blk_writer.sv
module sd_blk_writer
    import sdw_pkg::*;
#(
    parameter int BLK_BYTES  = 512,
    parameter int CNT_W      = 8,
    parameter int BUSY_POLLS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             multi,
    input  logic [CNT_W-1:0] nblk,
    output logic             busy,
    output logic             done,
    output logic [2:0]       status,
    input  logic             pl_valid,
    input  logic [7:0]       pl_data,
    output logic             pl_ready,
    output logic             byte_req,
    output logic [7:0]       byte_tx,
    input  logic             byte_gnt,
    input  logic [7:0]       byte_rx,
    output logic             stop_req,
    input  logic             stop_ack
);
    localparam int IDX_W = $clog2(BLK_BYTES);

    sdw_state_t       state_q, state_d;
    sdw_status_t      status_q, status_d;
    logic             multi_q, stopping_q;
    logic [CNT_W-1:0] left_q;
    logic [IDX_W-1:0] idx_q;
    logic [15:0]      crc;
    sdw_rsp_t         rsp_kind;
    logic             poll_last;
    logic             xfer, idx_last, blk_last;
    sdw_state_t       ready_next;

    assign xfer     = byte_req && byte_gnt;
    assign idx_last = (idx_q == IDX_W'(BLK_BYTES - 1));
    assign blk_last = (left_q == CNT_W'(1));

    sdw_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == S_TOKEN),
        .en    (state_q == S_DATA && xfer),
        .din   (byte_tx),
        .crc   (crc)
    );

    sdw_rsp_decode u_dec (
        .rx   (byte_rx),
        .kind (rsp_kind)
    );

    sdw_poll_timer #(.LIMIT(BUSY_POLLS)) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != S_BUSY),
        .tick  (state_q == S_BUSY && xfer && byte_rx == BUSY_BYTE),
        .last  (poll_last)
    );

    // Where to go once the card reports ready.
    always_comb begin
        if (stopping_q)                ready_next = S_FINISH;
        else if (multi_q && !blk_last) ready_next = S_TOKEN;
        else if (multi_q)              ready_next = S_STOP;
        else                           ready_next = S_FINISH;
    end

    // Next state and end-of-job status.
    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        unique case (state_q)
            S_IDLE:   if (start) begin
                          state_d  = S_TOKEN;
                          status_d = ST_OK;
                      end
            S_TOKEN:  if (xfer) state_d = S_DATA;
            S_DATA:   if (xfer && idx_last) state_d = S_CRC_HI;
            S_CRC_HI: if (xfer) state_d = S_CRC_LO;
            S_CRC_LO: if (xfer) state_d = S_RESP;
            S_RESP:   if (xfer) begin
                          unique case (rsp_kind)
                              RSP_ACCEPT: state_d = S_BUSY;
                              RSP_CRC:    begin state_d = S_FINISH; status_d = ST_CRC_REJ;  end
                              RSP_WRITE:  begin state_d = S_FINISH; status_d = ST_WR_REJ;   end
                              RSP_OTHER:  begin state_d = S_FINISH; status_d = ST_BAD_RESP; end
                          endcase
                      end
            S_BUSY:   if (xfer) begin
                          if (byte_rx == IDLE_BYTE) state_d = ready_next;
                          else if (byte_rx == BUSY_BYTE) begin
                              if (poll_last) begin
                                  state_d  = S_FINISH;
                                  status_d = ST_TIMEOUT;
                              end
                          end else state_d = S_RECHECK;
                      end
            S_RECHECK: if (xfer) begin
                          if (byte_rx == IDLE_BYTE) state_d = ready_next;
                          else begin
                              state_d  = S_FINISH;
                              status_d = ST_PROTO;
                          end
                      end
            S_STOP:   if (stop_ack) state_d = S_BUSY;
            S_FINISH: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            status_q <= ST_OK;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    // Job bookkeeping: mode, remaining blocks, byte index, stop phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            multi_q    <= 1'b0;
            stopping_q <= 1'b0;
            left_q     <= '0;
            idx_q      <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                multi_q    <= multi;
                stopping_q <= 1'b0;
                left_q     <= (!multi || nblk == '0) ? CNT_W'(1) : nblk;
            end
            if (state_q == S_TOKEN && xfer)     idx_q <= '0;
            else if (state_q == S_DATA && xfer) idx_q <= idx_q + 1'b1;
            if ((state_q == S_BUSY || state_q == S_RECHECK) && state_d == S_TOKEN)
                left_q <= left_q - 1'b1;
            if (state_q == S_STOP && stop_ack) stopping_q <= 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        byte_req = 1'b0;
        byte_tx  = IDLE_BYTE;
        unique case (state_q)
            S_TOKEN:  begin byte_req = 1'b1; byte_tx = multi_q ? TOK_MULTI : TOK_ONE; end
            S_DATA:   begin byte_req = pl_valid; byte_tx = pl_data; end
            S_CRC_HI: begin byte_req = 1'b1; byte_tx = crc[15:8]; end
            S_CRC_LO: begin byte_req = 1'b1; byte_tx = crc[7:0]; end
            S_RESP, S_BUSY, S_RECHECK: byte_req = 1'b1;
            default:  ;
        endcase
        pl_ready = (state_q == S_DATA) && pl_valid && byte_gnt;
        stop_req = (state_q == S_STOP);
        done     = (state_q == S_FINISH);
        busy     = (state_q != S_IDLE);
        status   = status_q;
    end
endmodule

// File: rtl/sdw_checker.sv
module sdw_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] status,
    input logic       pl_valid,
    input logic [7:0] pl_data,
    input logic       pl_ready,
    input logic       byte_req,
    input logic [7:0] byte_tx,
    input logic       byte_gnt,
    input logic       stop_req,
    input logic       stop_ack
);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req && !byte_gnt |=> byte_req && $stable(byte_tx));

    p_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pl_ready |-> pl_valid && byte_req && byte_gnt && byte_tx == pl_data);

    p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req && !stop_ack |=> stop_req);

    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(stop_req && byte_req));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !byte_req && !stop_req && !done);

    p_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> status <= 3'd5);
endmodule

bind sd_blk_writer sdw_checker i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .status   (status),
    .pl_valid (pl_valid),
    .pl_data  (pl_data),
    .pl_ready (pl_ready),
    .byte_req (byte_req),
    .byte_tx  (byte_tx),
    .byte_gnt (byte_gnt),
    .stop_req (stop_req),
    .stop_ack (stop_ack)
);

// File: tb/test_sd_blk_writer.sv
`timescale 1ns/1ps
module test_sd_blk_writer;
    localparam int BLK   = 512;
    localparam int POLLS = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0, multi = 1'b0;
    logic [7:0] nblk = '0;
    logic       busy, done, pl_ready, byte_req, stop_req;
    logic [2:0] status;
    logic       pl_valid = 1'b0;
    logic [7:0] pl_data = '0;
    logic [7:0] byte_tx;
    logic       byte_gnt = 1'b0;
    logic [7:0] byte_rx = 8'hFF;
    logic       stop_ack = 1'b0;

    always #2.5 clk = ~clk;

    sd_blk_writer i_sd_blk_writer (
        .clk(clk), .rst_n(rst_n), .start(start), .multi(multi), .nblk(nblk),
        .busy(busy), .done(done), .status(status),
        .pl_valid(pl_valid), .pl_data(pl_data), .pl_ready(pl_ready),
        .byte_req(byte_req), .byte_tx(byte_tx), .byte_gnt(byte_gnt), .byte_rx(byte_rx),
        .stop_req(stop_req), .stop_ack(stop_ack)
    );

    int total = 0, bad = 0, cyc = 0;
    int scen = 0, pl_idx = 0, stops = 0;
    bit taken = 0;
    logic [7:0] exp_tx[$];
    logic [7:0] card_rx[$];
    string      exp_tag[$];

    function automatic logic [7:0] pay(int s, int i);
        return 8'((i * 7) + (i >> 3) + (s * 29) + 5);
    endfunction

    function automatic logic [15:0] crc_ref(int s, int b);
        logic [15:0] c = 16'h0;
        for (int i = 0; i < BLK; i++) begin
            logic [7:0] d = pay(s, b * BLK + i);
            for (int k = 7; k >= 0; k--) begin
                logic fb = c[15] ^ d[k];
                c = c << 1;
                if (fb) c = c ^ 16'h1021;
            end
        end
        return c;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s scenario %0d: actual=%0h expected=%0h", req, scen, act, exp);
        end
    endtask

    task automatic add(logic [7:0] tx, logic [7:0] rx, string tag);
        exp_tx.push_back(tx);
        card_rx.push_back(rx);
        exp_tag.push_back(tag);
    endtask

    task automatic add_block(logic [7:0] tok, int b, logic [7:0] resp);
        logic [15:0] c = crc_ref(scen, b);
        add(tok, 8'hFF, "R1");
        for (int i = 0; i < BLK; i++) add(pay(scen, b * BLK + i), 8'hFF, "R2");
        add(c[15:8], 8'hFF, "R3");
        add(c[7:0], 8'hFF, "R3");
        add(8'hFF, resp, "R4");
    endtask

    task automatic add_polls(int zeros, logic [7:0] fin);
        for (int i = 0; i < zeros; i++) add(8'hFF, 8'h00, "R5");
        add(8'hFF, fin, "R5");
    endtask

    // Stimulus for the card side and the payload stream.
    always @(negedge clk) begin
        cyc++;
        if (!pl_valid || taken) pl_valid <= (cyc % 5 != 3);
        taken = 0;
        pl_data  <= pay(scen, pl_idx);
        byte_gnt <= (cyc % 4 != 1);
        byte_rx  <= (card_rx.size() != 0) ? card_rx[0] : 8'hFF;
        stop_ack <= stop_req && (cyc % 3 == 0);
    end

    // Reference comparison of every exchange, just before the edge.
    always @(negedge clk) begin
        #1;
        if (rst_n && byte_req && byte_gnt) begin
            if (exp_tx.size() == 0) check("R2 extra byte", byte_tx, 256);
            else begin
                check(exp_tag[0], byte_tx, exp_tx[0]);
                void'(exp_tx.pop_front());
                void'(card_rx.pop_front());
                void'(exp_tag.pop_front());
            end
        end
        if (rst_n && pl_ready) begin
            pl_idx++;
            taken = 1;
        end
        if (rst_n && stop_req && stop_ack) stops++;
    end

    task automatic run(bit m, int n, int exp_status, int exp_stops, bit poke);
        int waited = 0;
        pl_idx = 0;
        stops  = 0;
        @(negedge clk);
        start = 1'b1; multi = m; nblk = 8'(n);
        @(negedge clk);
        start = 1'b0;
        #1 check("R9 busy after start", busy, 1);
        while (!done && waited < 30000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 100) begin
                start = 1'b1; multi = 1'b1; nblk = 8'd3;
            end else start = 1'b0;
            #1;
        end
        check("R9 done reached", done, 1);
        check("R9 busy with done", busy, 1);
        check("R4 status", status, exp_status);
        check("R8 stop count", stops, exp_stops);
        check("R2 exchanges left", exp_tx.size(), 0);
        @(negedge clk);
        #1 check("R9 idle after done", {busy, done}, 0);
        exp_tx.delete(); card_rx.delete(); exp_tag.delete();
        scen++;
    endtask

    initial begin
        #2000000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        check("R9 reset busy", busy, 0);
        check("R9 reset done", done, 0);
        check("R9 reset req", byte_req, 0);
        check("R8 reset stop", stop_req, 0);
        rst_n = 1'b1;

        // R1 R5: single block, three busy polls then ready
        add_block(8'hFE, 0, 8'hE5); add_polls(3, 8'hFF);
        run(0, 0, 0, 0, 0);
        // R8 R6: multi, three blocks, mid-byte release then ready
        for (int b = 0; b < 3; b++) begin
            add_block(8'hFC, b, 8'h05); add(8'hFF, 8'h07, "R6"); add(8'hFF, 8'hFF, "R6");
        end
        add_polls(2, 8'hFF);
        run(1, 3, 0, 1, 0);
        // R4: CRC reject, write reject, unknown response
        add_block(8'hFE, 0, 8'h0B); run(0, 1, 1, 0, 0);
        add_block(8'hFE, 0, 8'hED); run(0, 1, 2, 0, 0);
        add_block(8'hFE, 0, 8'h1F); run(0, 1, 3, 0, 0);
        // R6: odd byte followed by non-ready
        add_block(8'hFE, 0, 8'h05); add(8'hFF, 8'h3C, "R6"); add(8'hFF, 8'h00, "R6");
        run(0, 1, 4, 0, 0);
        // R7: timeout after exactly POLLS zeros
        add_block(8'hFE, 0, 8'h05);
        for (int i = 0; i < POLLS; i++) add(8'hFF, 8'h00, "R7");
        run(0, 1, 5, 0, 0);
        // R7: one poll short of the limit still succeeds
        add_block(8'hFE, 0, 8'h05); add_polls(POLLS - 1, 8'hFF);
        run(0, 1, 0, 0, 0);
        // R8: nblk of 0 in multi mode acts as one block
        add_block(8'hFC, 0, 8'h05); add_polls(0, 8'hFF); add_polls(1, 8'hFF);
        run(1, 0, 0, 1, 0);
        // R9: start while busy ignored
        add_block(8'hFE, 0, 8'h05); add_polls(1, 8'hFF);
        run(0, 1, 0, 0, 1);
        // R8: reject on second block of a multi job, no stop
        add_block(8'hFC, 0, 8'h05); add_polls(0, 8'hFF); add_block(8'hFC, 1, 8'h0D);
        run(1, 2, 2, 0, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule